// File: doc/BRIEF.md
# Lock-Protected Watchdog Timer

This block is a watchdog timer built around a 24-bit down-counter. Software sets the timeout period through three byte-wide reload registers on a small byte bus. Those registers refuse writes until a two-byte key has been written to a shared control address. A refresh strobe, standing in for the processor's watchdog-service instruction, copies the reload value into the counter. A tick enable paces the count. When the counter runs out, the block raises a one-cycle timeout pulse, records the event in a status byte and starts the next period from the reload value.

The control address is write-only for unlocking. A read at that address returns a status byte that clears itself on read. The reload addresses return the bytes of the live counter, not the stored reload value. A reload value below four is raised to four when it is loaded, so a period can never be shorter than four ticks.

Top module: `guarded_wdt`

## Requirements
- R1: After reset the reload value is 0xFFFFFF, the reload registers are locked, the counter holds 0xFFFFFF and the status byte reads 0x80.
- R2: Writing 0x55 and then 0xAA to the control address 0xFF0 unlocks the reload registers. The reload bytes are then writable at 0xFF1 (bits 23:16), 0xFF2 (bits 15:8) and 0xFF3 (bits 7:0).
- R3: A reload write made while the registers are locked leaves the reload value unchanged.
- R4: Any control write other than the expected next key byte returns the sequence to locked. After 0x55, only 0xAA completes the unlock. A later 0x55, 0xAA pair still unlocks.
- R5: A write to the low reload byte at 0xFF3 locks the registers again.
- R6: A refresh loads the reload value into the counter. A reload value below 0x000004 is loaded as 0x000004.
- R7: A read at 0xFF1, 0xFF2 or 0xFF3 returns bits 23:16, 15:8 or 7:0 of the current counter.
- R8: Each cycle with tick enable high lowers the counter by one, and without a tick or refresh the counter holds. A tick while the counter is 1 drives timeout high for exactly the next cycle and reloads the counter instead of reaching zero.
- R9: The status byte at 0xFF0 has bit 0 = timeout flag and bit 7 = reset flag, with all other bits 0. A read with the read strobe clears both flags after that read, a timeout in the same cycle sets bit 0 anyway, and control writes do not change the status byte.
- R10: A refresh in the same cycle as a tick takes priority: the counter loads the reload value and no timeout occurs.
- R11: A read at any other address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 12 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; clears the status flags when the control address is read |
| bus_rdata | output | 8 | Read data for the current address |
| refresh | input | 1 | Loads the reload value into the counter |
| tick_en | input | 1 | Count enable; one decrement per high cycle |
| timeout | output | 1 | One-cycle pulse when the counter runs out |

## Verification
The hardest case to reach is the end of a period. The 0xFFFFFF reset period is far too long to run out in a bench, so the stimulus first unlocks the registers and loads a short period. It then drives an exact number of tick cycles, checks the timeout at each of them, and reads the counter at the end to confirm the reload. The same approach, with a reload value of one, shows the clamp to four. Counting down to 1 and then sending refresh and tick in the same cycle shows that refresh takes priority.

// File: rtl/gwdt_pkg.sv
package gwdt_pkg;

  typedef enum logic [1:0] {
    UL_LOCKED = 2'd0,
    UL_HALF   = 2'd1,
    UL_OPEN   = 2'd2
  } unlock_e;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  localparam int STAT_TMO_BIT = 0;
  localparam int STAT_RST_BIT = 7;

endpackage

// File: rtl/gwdt_unlock.sv
module gwdt_unlock
  import gwdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic       low_wr,
  input  logic [7:0] wdata,
  output logic       open
);

  unlock_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (ctrl_wr) begin
      if (st_q == UL_HALF && wdata == KEY_SECOND) begin
        st_d = UL_OPEN;
      end else if (st_q != UL_HALF && wdata == KEY_FIRST) begin
        st_d = UL_HALF;
      end else begin
        st_d = UL_LOCKED;
      end
    end else if (low_wr && st_q == UL_OPEN) begin
      st_d = UL_LOCKED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= UL_LOCKED;
    else        st_q <= st_d;
  end

  assign open = (st_q == UL_OPEN);

  // R2: the second key byte after the first opens the registers
  a_r2_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && st_q == UL_HALF && wdata == KEY_SECOND) |=> open);

  // R4: a wrong byte after the first key drops back to locked
  a_r4_wrong_byte_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && st_q == UL_HALF && wdata != KEY_SECOND) |=> (st_q == UL_LOCKED));

  // R5: a low reload byte write ends the open window
  a_r5_low_write_relocks: assert property (@(posedge clk) disable iff (!rst_n)
    (low_wr && !ctrl_wr && open) |=> !open);

endmodule

// File: rtl/gwdt_reload.sv
module gwdt_reload #(
  parameter int CNT_W = 24,
  localparam int NB = CNT_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NB-1:0]    wr_sel,
  input  logic [7:0]       wdata,
  input  logic             unlock_open,
  output logic [CNT_W-1:0] reload
);

  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic [7:0] byte_q, byte_d;
    logic       byte_en;

    always_comb begin
      byte_en = wr_sel[b] & unlock_open;
      byte_d  = byte_en ? wdata : byte_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q <= 8'hFF;
      else        byte_q <= byte_d;
    end

    assign reload[b*8 +: 8] = byte_q;
  end

  // R3: while locked, no write can move the reload value
  a_r3_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !unlock_open |=> $stable(reload));

endmodule

// File: rtl/gwdt_counter.sv
module gwdt_counter #(
  parameter int CNT_W    = 24,
  parameter int MIN_LOAD = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             refresh,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             timeout
);

  localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_LOAD);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, load_val;
  logic             tmo_q, tmo_d;

  always_comb begin
    load_val = (reload < FLOOR) ? FLOOR : reload;
    cnt_d    = cnt_q;
    tmo_d    = 1'b0;
    if (refresh) begin
      cnt_d = load_val;
    end else if (tick_en) begin
      if (cnt_q <= ONE) begin
        cnt_d = load_val;
        tmo_d = 1'b1;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
      tmo_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tmo_q <= tmo_d;
    end
  end

  assign cnt     = cnt_q;
  assign timeout = tmo_q;

  // R8: the timeout is a single-cycle pulse
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout);

  // R8: with no tick and no refresh the count holds
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !refresh) |=> $stable(cnt));

  // R6: the counter never rests at zero
  a_r6_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != '0);

  // R10: a refresh never produces a timeout
  a_r10_refresh_wins: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> !timeout);

endmodule

// File: rtl/gwdt_status.sv
module gwdt_status
  import gwdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       timeout,
  input  logic       rd_clr,
  output logic [7:0] status
);

  logic tmo_flag_q, tmo_flag_d;
  logic rst_flag_q, rst_flag_d;

  always_comb begin
    tmo_flag_d = timeout | (tmo_flag_q & ~rd_clr);
    rst_flag_d = rst_flag_q & ~rd_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_flag_q <= 1'b0;
      rst_flag_q <= 1'b1;
    end else begin
      tmo_flag_q <= tmo_flag_d;
      rst_flag_q <= rst_flag_d;
    end
  end

  always_comb begin
    status               = '0;
    status[STAT_TMO_BIT] = tmo_flag_q;
    status[STAT_RST_BIT] = rst_flag_q;
  end

  // R9: a timeout always lands in the flag
  a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> status[STAT_TMO_BIT]);

  // R9: a status read with no new timeout leaves both flags clear
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !timeout) |=> (status == 8'h00));

endmodule

// File: rtl/guarded_wdt.sv
module guarded_wdt #(
  parameter int              ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'hFF0,
  parameter int              CNT_W     = 24,
  parameter int              MIN_LOAD  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  input  logic              refresh,
  input  logic              tick_en,
  output logic              timeout
);

  localparam int NB = CNT_W / 8;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_int_n = rst_sync_q[1];

  // address decode: slot i follows the control address, upper byte first
  logic          ctrl_hit;
  logic [NB-1:0] slot_hit;
  logic [NB-1:0] wr_sel;

  assign ctrl_hit = (bus_addr == BASE_ADDR);

  for (genvar i = 0; i < NB; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(BASE_ADDR + ADDR_W'(i + 1));
    assign slot_hit[i]      = (bus_addr == SLOT_ADDR);
    assign wr_sel[NB-1-i]   = bus_wr & slot_hit[i];
  end

  logic             unlock_open;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       status;

  gwdt_unlock u_unlock (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .ctrl_wr (bus_wr & ctrl_hit),
    .low_wr  (wr_sel[0]),
    .wdata   (bus_wdata),
    .open    (unlock_open)
  );

  gwdt_reload #(.CNT_W(CNT_W)) u_reload (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .wr_sel      (wr_sel),
    .wdata       (bus_wdata),
    .unlock_open (unlock_open),
    .reload      (reload)
  );

  gwdt_counter #(.CNT_W(CNT_W), .MIN_LOAD(MIN_LOAD)) u_counter (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick_en (tick_en),
    .refresh (refresh),
    .reload  (reload),
    .cnt     (cnt),
    .timeout (timeout)
  );

  gwdt_status u_status (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .timeout (timeout),
    .rd_clr  (bus_rd & ctrl_hit),
    .status  (status)
  );

  // read mux: status at the control address, live count bytes at the slots
  always_comb begin
    bus_rdata = 8'h00;
    if (ctrl_hit) bus_rdata = status;
    for (int i = 0; i < NB; i++) begin
      if (slot_hit[i]) bus_rdata = cnt[(NB-1-i)*8 +: 8];
    end
  end

  // R11: an address outside the block reads as zero
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!ctrl_hit && slot_hit == '0) |-> (bus_rdata == 8'h00));

endmodule

// File: tb/guarded_wdt_bench.sv
module guarded_wdt_bench;

  localparam logic [11:0] CTRL = 12'hFF0;
  localparam logic [11:0] UPR  = 12'hFF1;
  localparam logic [11:0] HIGH = 12'hFF2;
  localparam logic [11:0] LOW  = 12'hFF3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_wr;
  logic        bus_rd;
  logic [7:0]  bus_rdata;
  logic        refresh;
  logic        tick_en;
  logic        timeout;

  always #10 clk = ~clk;

  guarded_wdt u_guarded_wdt (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .refresh   (refresh),
    .tick_en   (tick_en),
    .timeout   (timeout)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [7:0] exp_q[$];
  string      req_q[$];

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares each read against the queued expectation
  always @(negedge clk) begin
    #5;
    if (bus_rd) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "scoreboard", {24'h0, bus_rdata}, 32'hDEAD);
      end else begin
        logic [7:0] e;
        string      r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(bus_rdata == e, r, {24'h0, bus_rdata}, {24'h0, e});
      end
    end
  end

  task automatic wr(logic [11:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd_expect(logic [11:0] a, logic [7:0] e, string req);
    @(negedge clk);
    exp_q.push_back(e);
    req_q.push_back(req);
    bus_addr = a;
    bus_rd   = 1'b1;
    @(negedge clk);
    bus_rd   = 1'b0;
  endtask

  task automatic count_expect(logic [23:0] e, string req);
    rd_expect(UPR,  e[23:16], req);
    rd_expect(HIGH, e[15:8],  req);
    rd_expect(LOW,  e[7:0],   req);
  endtask

  task automatic unlock();
    wr(CTRL, 8'h55);
    wr(CTRL, 8'hAA);
  endtask

  task automatic set_reload(logic [23:0] v);
    wr(UPR,  v[23:16]);
    wr(HIGH, v[15:8]);
    wr(LOW,  v[7:0]);
  endtask

  task automatic do_refresh();
    @(negedge clk);
    refresh = 1'b1;
    @(negedge clk);
    refresh = 1'b0;
  endtask

  // n consecutive ticks; timeout expected only after tick number hit (0 = never)
  task automatic tick_run(int n, int hit, string req);
    @(negedge clk);
    tick_en = 1'b1;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (k == n) tick_en = 1'b0;
      #5;
      check(timeout == (k == hit), req, {31'h0, timeout}, {31'h0, (k == hit)});
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    bus_wr    = 1'b0;
    bus_rd    = 1'b0;
    refresh   = 1'b0;
    tick_en   = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state of counter and status
    #5;
    check(timeout == 1'b0, "R1", {31'h0, timeout}, 32'h0);
    count_expect(24'hFFFFFF, "R1");
    rd_expect(CTRL, 8'h80, "R1 R9 status after reset");
    rd_expect(CTRL, 8'h00, "R9 read clears");

    // R11: unmapped addresses
    rd_expect(12'h123, 8'h00, "R11");
    rd_expect(12'hFF4, 8'h00, "R11");

    // R3: writes while locked are ignored
    wr(LOW, 8'h20);
    wr(UPR, 8'h00);
    do_refresh();
    count_expect(24'hFFFFFF, "R3");

    // R2 and R7: unlock, program, refresh, read live count
    unlock();
    set_reload(24'h000100);
    do_refresh();
    count_expect(24'h000100, "R2 R7");

    // R5: low byte write relocked the registers
    wr(LOW, 8'h08);
    do_refresh();
    count_expect(24'h000100, "R5");

    // R4: broken sequences
    wr(CTRL, 8'h55); wr(CTRL, 8'h12); wr(CTRL, 8'hAA);
    wr(LOW, 8'h08);
    do_refresh();
    count_expect(24'h000100, "R4 wrong byte");
    wr(CTRL, 8'h55); wr(CTRL, 8'h55); wr(CTRL, 8'hAA);
    wr(LOW, 8'h08);
    do_refresh();
    count_expect(24'h000100, "R4 repeated first key");
    unlock();
    set_reload(24'h000006);
    do_refresh();
    count_expect(24'h000006, "R4 later unlock");

    // R8: decrement, hold, expiry and reload
    tick_run(3, 0, "R8 no early timeout");
    count_expect(24'h000003, "R8 decrement");
    repeat (5) @(negedge clk);
    count_expect(24'h000003, "R8 hold");
    tick_run(3, 3, "R8 timeout pulse");
    count_expect(24'h000006, "R8 reload on expiry");
    rd_expect(CTRL, 8'h01, "R9 timeout flag");
    rd_expect(CTRL, 8'h00, "R9 flag cleared");

    // R6: clamp to four
    unlock();
    set_reload(24'h000001);
    do_refresh();
    count_expect(24'h000004, "R6 clamp");
    tick_run(4, 4, "R6 clamped period");
    count_expect(24'h000004, "R6 clamped reload");
    rd_expect(CTRL, 8'h01, "R9 timeout flag");

    // R10: refresh beats tick at count 1
    tick_run(3, 0, "R10 approach");
    @(negedge clk);
    refresh = 1'b1;
    tick_en = 1'b1;
    @(negedge clk);
    refresh = 1'b0;
    tick_en = 1'b0;
    #5;
    check(timeout == 1'b0, "R10", {31'h0, timeout}, 32'h0);
    count_expect(24'h000004, "R10");

    // R9: control writes leave status untouched
    wr(CTRL, 8'hFF);
    wr(CTRL, 8'h55);
    rd_expect(CTRL, 8'h00, "R9 ctrl write no effect");

    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule